// File: doc/BRIEF.md
# Joypad Matrix Select Register

This block is an 8-bit memory-mapped register that scans a keypad wired as two groups of four buttons. Software writes a two-bit select field that chooses which group, or both groups, drive the four result lines in the low nibble of the register. All buttons and result lines are active low: a pressed button reads as 0.

The select field is held in a small state machine with four named states. SEL_BOTH (field 2'b00) combines both groups with a bitwise AND. SEL_HIGH (field 2'b01) shows the upper button group. SEL_LOW (field 2'b10) shows the lower button group. SEL_NONE (field 2'b11) shows no group. Every register write is a transition to the state named by write-data bits 5:4, from any state, including the current one. With no write, the machine stays where it is. The result lines follow the button inputs combinationally in every state, so a press is visible without a new write.

A fall detector watches the four result lines. Whenever any line goes from 1 to 0, it emits a one-cycle request pulse for the joypad interrupt. The fall may come from a select change or from a button press. The interrupt controller that consumes the pulse lives outside this block.

Top module: `joypad_select_reg`

## Requirements
- R1: A write (wr_en high at a rising clock edge) stores only wr_data[5:4] as the select field. From the next cycle the field reads back in rd_data[5:4], and the other write bits have no effect.
- R2: rd_data[7:6] always reads 2'b11 while rd_en is high, whatever was written to those bits.
- R3: With the select field at 2'b10, rd_data[3:0] equals buttons[3:0] in the same cycle.
- R4: With the select field at 2'b01, rd_data[3:0] equals buttons[7:4] in the same cycle.
- R5: With the select field at 2'b00, rd_data[3:0] equals buttons[3:0] & buttons[7:4], so a line reads 0 if either group holds it low.
- R6: With the select field at 2'b11, rd_data[3:0] reads 4'hF regardless of the buttons.
- R7: After reset, the select field is 2'b00. With all buttons released (8'hFF), the register reads 8'hCF and irq_pulse is low.
- R8: A write that makes any result line fall from 1 to 0 drives irq_pulse high for exactly one cycle. The pulse appears in the cycle after the one in which the new select value first takes effect. A write that only raises lines produces no pulse.
- R9: A button change that makes a selected result line fall drives irq_pulse high in the cycle right after the change. A change confined to an unselected group produces no pulse.
- R10: While rd_en is low, rd_data is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; only bits 5:4 are kept |
| rd_en | input | 1 | Register read strobe; gates rd_data |
| buttons | input | 8 | Button state, active low; [3:0] lower group, [7:4] upper group |
| rd_data | output | 8 | Register value while rd_en is high, else 0 |
| irq_pulse | output | 1 | One-cycle joypad interrupt request |

## Verification
A write-induced fall and a button-induced fall can both reach the fall detector in back-to-back cycles. To provoke this, the bench presses a button in the selected lower group on the same cycle that it writes the select field to choose the upper group. The press makes bit 0 fall right away, and the new select makes bit 3 fall one edge later. The bench expects irq_pulse high in two consecutive cycles and low in the third, which shows that neither event is lost or merged.

// File: rtl/joy_pkg.sv
package joy_pkg;

    // States of the select register; the encoding equals the stored field.
    typedef enum logic [1:0] {
        SEL_BOTH = 2'b00,
        SEL_HIGH = 2'b01,
        SEL_LOW  = 2'b10,
        SEL_NONE = 2'b11
    } joy_sel_e;

    localparam int SEL_W = 2;

endpackage

// File: rtl/joy_sel_fsm.sv
module joy_sel_fsm
    import joy_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output joy_sel_e         sel_q
);

    joy_sel_e sel_d;
    logic [SEL_W-1:0] sel_bits;

    assign sel_bits = sel_q;

    // Next state: a write moves to the state named by the field.
    always_comb begin
        sel_d = sel_q;
        if (wr_en) begin
            unique case (wr_sel)
                2'b00:   sel_d = SEL_BOTH;
                2'b01:   sel_d = SEL_HIGH;
                2'b10:   sel_d = SEL_LOW;
                default: sel_d = SEL_NONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= SEL_BOTH;
        else        sel_q <= sel_d;
    end

    p_sel_follows_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (sel_bits == $past(wr_sel)));

    p_sel_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(sel_bits));

endmodule

// File: rtl/joy_matrix_mux.sv
module joy_matrix_mux
    import joy_pkg::*;
#(
    parameter int LINE_W = 4,
    localparam int BTN_W = 2 * LINE_W
) (
    input  joy_sel_e          sel,
    input  logic [BTN_W-1:0]  buttons,
    output logic [LINE_W-1:0] lines
);

    logic [LINE_W-1:0] grp_low;
    logic [LINE_W-1:0] grp_high;

    assign grp_low  = buttons[LINE_W-1:0];
    assign grp_high = buttons[BTN_W-1:LINE_W];

    // Output decode per state.
    always_comb begin
        unique case (sel)
            SEL_BOTH: lines = grp_low & grp_high;
            SEL_HIGH: lines = grp_high;
            SEL_LOW:  lines = grp_low;
            SEL_NONE: lines = '1;
            default:  lines = '1;
        endcase
    end

endmodule

// File: rtl/joy_fall_detect.sv
module joy_fall_detect #(
    parameter int LINE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] lines_in,
    output logic              irq_pulse
);

    logic [LINE_W-1:0] lines_q;
    logic [LINE_W-1:0] fall;

    for (genvar i = 0; i < LINE_W; i++) begin : g_fall
        assign fall[i] = lines_q[i] & ~lines_in[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_q   <= '1;
            irq_pulse <= 1'b0;
        end else begin
            lines_q   <= lines_in;
            irq_pulse <= |fall;
        end
    end

    // A request implies some line was low in the cycle before (R8, R9).
    p_irq_needs_low_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> ($past(lines_in) != '1));

    p_no_irq_when_all_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lines_in == '1) |=> !irq_pulse);

endmodule

// File: rtl/joypad_select_reg.sv
module joypad_select_reg
    import joy_pkg::*;
#(
    parameter int LINE_W = 4,
    localparam int BTN_W = 2 * LINE_W,
    localparam int REG_W = LINE_W + SEL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [BTN_W-1:0] buttons,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_pulse
);

    joy_sel_e          sel_q;
    logic [SEL_W-1:0]  sel_bits;
    logic [LINE_W-1:0] lines;
    logic              unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[REG_W-1:LINE_W+SEL_W], wr_data[LINE_W-1:0]};

    joy_sel_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_data[LINE_W +: SEL_W]),
        .sel_q  (sel_q)
    );

    joy_matrix_mux #(.LINE_W(LINE_W)) u_mux (
        .sel     (sel_q),
        .buttons (buttons),
        .lines   (lines)
    );

    joy_fall_detect #(.LINE_W(LINE_W)) u_fall (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_in  (lines),
        .irq_pulse (irq_pulse)
    );

    assign sel_bits = sel_q;
    assign rd_data  = rd_en ? {2'b11, sel_bits, lines} : '0;

    p_top_bits_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (rd_data[REG_W-1 -: 2] == 2'b11));

    p_none_reads_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_data[LINE_W +: SEL_W] == 2'b11) |-> (rd_data[LINE_W-1:0] == '1));

    p_both_is_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_data[LINE_W +: SEL_W] == 2'b00)
        |-> (rd_data[LINE_W-1:0] == (buttons[LINE_W-1:0] & buttons[BTN_W-1:LINE_W])));

    p_idle_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));

endmodule

// File: tb/joypad_select_reg_test.sv
`timescale 1ns/1ps
module joypad_select_reg_test;

    localparam real CLK_NS = 5.0;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b1;
    logic [7:0] buttons = 8'hFF;
    logic [7:0] rd_data;
    logic       irq_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_NS / 2.0) clk = ~clk;

    joypad_select_reg uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .buttons   (buttons),
        .rd_data   (rd_data),
        .irq_pulse (irq_pulse)
    );

    // {select, buttons, expected read value}
    localparam logic [17:0] VEC [8] = '{
        {2'b10, 8'hA5, 8'hE5},
        {2'b01, 8'hA5, 8'hDA},
        {2'b00, 8'hA5, 8'hC0},
        {2'b11, 8'hA5, 8'hFF},
        {2'b00, 8'h7E, 8'hC6},
        {2'b10, 8'h7E, 8'hEE},
        {2'b01, 8'h7E, 8'hD7},
        {2'b11, 8'h00, 8'hFF}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Write a select value with junk in all other bits; returns at the
    // falling edge after the write edge.
    task automatic write_sel(input logic [1:0] s);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = {2'b01, s, 4'b1010};
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 reset read", rd_data, 8'hCF);
        chk("R7 reset irq", {7'b0, irq_pulse}, 8'h00);
        rst_n = 1'b1;
        idle(1);
        chk("R7 read after reset", rd_data, 8'hCF);
        rd_en = 1'b0;
        #1 chk("R10 idle read", rd_data, 8'h00);
        rd_en = 1'b1;

        // Table walk: R1..R6
        for (int i = 0; i < 8; i++) begin
            buttons = VEC[i][15:8];
            write_sel(VEC[i][17:16]);
            chk($sformatf("R1/R2/R3-R6 vector %0d", i), rd_data, VEC[i][7:0]);
        end

        // R3 tracking without a write
        write_sel(2'b10);
        buttons = 8'hF3;
        #1 chk("R3 tracks buttons", rd_data, 8'hE3);

        // R8: write-induced fall
        buttons = 8'hFE;
        write_sel(2'b11);
        idle(3);
        write_sel(2'b10);
        chk("R8 irq at write edge", {7'b0, irq_pulse}, 8'h00);
        idle(1);
        chk("R8 irq pulse", {7'b0, irq_pulse}, 8'h01);
        idle(1);
        chk("R8 irq one cycle", {7'b0, irq_pulse}, 8'h00);
        // R8: rising lines give nothing
        write_sel(2'b11);
        chk("R8 rise no irq a", {7'b0, irq_pulse}, 8'h00);
        idle(1);
        chk("R8 rise no irq b", {7'b0, irq_pulse}, 8'h00);

        // R9: button-induced fall in selected group
        buttons = 8'hFF;
        write_sel(2'b01);
        idle(3);
        buttons = 8'hDF;
        idle(1);
        chk("R9 button fall irq", {7'b0, irq_pulse}, 8'h01);
        idle(1);
        chk("R9 button irq one cycle", {7'b0, irq_pulse}, 8'h00);
        buttons = 8'hD0;
        idle(1);
        chk("R9 unselected no irq a", {7'b0, irq_pulse}, 8'h00);
        idle(1);
        chk("R9 unselected no irq b", {7'b0, irq_pulse}, 8'h00);
        chk("R4 unselected no effect", rd_data, 8'hDD);

        // Same-cycle: button fall plus select change, back-to-back pulses
        buttons = 8'hFF;
        write_sel(2'b10);
        idle(3);
        @(negedge clk);
        buttons = 8'h7E;
        wr_en   = 1'b1;
        wr_data = 8'h10;
        @(negedge clk);
        wr_en   = 1'b0;
        chk("R9 overlap first pulse", {7'b0, irq_pulse}, 8'h01);
        chk("R4 overlap read", rd_data, 8'hD7);
        idle(1);
        chk("R8 overlap second pulse", {7'b0, irq_pulse}, 8'h01);
        idle(1);
        chk("R8 overlap end", {7'b0, irq_pulse}, 8'h00);

        rd_en = 1'b0;
        #1 chk("R10 read gated", rd_data, 8'h00);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule